// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Timer with Sampling Trigger

This block times a three-phase motor bridge. An internal counter climbs from zero to a top value and falls back again, so one PWM period lasts twice the top value in clock cycles and has two turning points. Each phase compares the counter with its duty value and drives a complementary pair of gate outputs, a high-side and a low-side, with a programmable dead gap in which both are off. The high side conducts while the counter is below the duty, so the low side conducts around the top turning point.

A fourth compare value exists only to start a current measurement. It yields a one-clock pulse when the counter meets it on the way down and never on the way up. The pulse therefore lands inside the low-side conduction window, where the shunt current can be read. Duty and compare values are written into holding registers at any time. They become active at one selected turning point per period, so every period runs with one consistent set of values. A build parameter starts the counter at its top and falling instead of at zero and rising. A second instance built that way runs half a period behind the first, and two motors can share one converter without both sampling at the same moment.

Top module: `tri_pwm_adc_timer`

## Requirements
- R1: `dir_down` is high for exactly PERIOD consecutive cycles and then low for exactly PERIOD cycles, so one PWM period is 2*PERIOD cycles.
- R2: `adc_trig` is a single-cycle pulse. It occurs exactly once per period, and only in a cycle where `dir_down` is high.
- R3: For an active compare value C with 1 <= C <= PERIOD, `adc_trig` is high exactly PERIOD-C cycles after the cycle in which `dir_down` rises. For C = PERIOD it is high in that same cycle.
- R4: A compare value of 0 produces no trigger at all, because the counter reaches 0 only while it is rising.
- R5: For a duty d with 1 <= d <= PERIOD, each phase drives its high-side output for max(0, 2d-1-DEAD) cycles per period and its low-side output for max(0, 2*PERIOD-2d+1-DEAD) cycles per period.
- R6: A duty of 0 holds the low side on and the high side off for the whole period. A duty above PERIOD holds the high side on and the low side off.
- R7: The high and low outputs of one phase are never high together. Every changeover between them passes through DEAD cycles in which both are low.
- R8: Written duty and compare values stay inactive until the next top turning point, where all of them take effect together. A write partway through a period leaves the rest of that period unchanged.
- R9: An instance built with HALF_SHIFT = 1 and fed the same values pulses `adc_trig` exactly PERIOD cycles after an instance built with HALF_SHIFT = 0.
- R10: While `rst` is high, all gate outputs, `adc_trig` and `dir_down` (of an unshifted instance) are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Captures the three duties and the compare value into the holding registers |
| duty_u | input | CNT_W | Duty value for phase U |
| duty_v | input | CNT_W | Duty value for phase V |
| duty_w | input | CNT_W | Duty value for phase W |
| trig_cmp | input | CNT_W | Counter value at which a falling-count trigger fires |
| gate_hi | output | 3 | High-side gate drives, bit 0 = U, bit 1 = V, bit 2 = W |
| gate_lo | output | 3 | Low-side gate drives, same bit order as gate_hi |
| adc_trig | output | 1 | One-clock start pulse for the converter |
| dir_down | output | 1 | High while the counter is falling |

## Verification
The reload of holding registers and the trigger can fall in the same cycle. This happens when the compare value equals the top, because the top is both the reload point and the first falling-count state. The bench programs C = PERIOD together with new duties. It then checks that the trigger still comes once per period, in the same cycle as the rise of `dir_down`, and that the measured high and low on-times match the new duties. A second case writes new duties just after a trigger and requires that the period in progress keeps the on-times of the old duties.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  // Which turning point of the counter loads the holding registers.
  typedef enum logic {
    TURN_BOTTOM = 1'b0,
    TURN_TOP    = 1'b1
  } turn_e;

  localparam int PHASES = 3;
endpackage

// File: rtl/pwm3_updown_ctr.sv
module pwm3_updown_ctr #(
  parameter int CNT_W      = 12,
  parameter int PERIOD     = 2000,
  parameter bit START_HIGH = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt,
  output logic             falling
);
  localparam logic [CNT_W-1:0] TOP    = CNT_W'(PERIOD);
  localparam logic [CNT_W-1:0] TOP_M1 = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= START_HIGH ? TOP : '0;
      falling <= START_HIGH;
    end else if (!falling) begin
      cnt <= cnt + ONE;
      if (cnt == TOP_M1) falling <= 1'b1;
    end else begin
      cnt <= cnt - ONE;
      if (cnt == ONE) falling <= 1'b0;
    end
  end

  AST_CNT_RANGE:  assert property (@(posedge clk) disable iff (rst) cnt <= TOP);                    // R1
  AST_TOP_BOUNCE: assert property (@(posedge clk) disable iff (rst) (cnt == TOP) |=> (cnt == TOP_M1)); // R1
  AST_BOT_BOUNCE: assert property (@(posedge clk) disable iff (rst) (cnt == '0) |=> (cnt == ONE));    // R1
endmodule

// File: rtl/pwm3_shadow.sv
module pwm3_shadow #(
  parameter int CNT_W = 12,
  parameter int N     = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [N-1:0][CNT_W-1:0]   duty_in,
  input  logic [CNT_W-1:0]          cmp_in,
  input  logic                      load,
  output logic [N-1:0][CNT_W-1:0]   duty_act,
  output logic [CNT_W-1:0]          cmp_act
);
  logic [N-1:0][CNT_W-1:0] duty_hold;
  logic [CNT_W-1:0]        cmp_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_hold <= '0;
      cmp_hold  <= '0;
    end else if (wr_en) begin
      duty_hold <= duty_in;
      cmp_hold  <= cmp_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_act <= '0;
      cmp_act  <= '0;
    end else if (load) begin
      duty_act <= duty_hold;
      cmp_act  <= cmp_hold;
    end
  end

  AST_HOLD_DUTY: assert property (@(posedge clk) disable iff (rst) !load |=> $stable(duty_act)); // R8
  AST_HOLD_CMP:  assert property (@(posedge clk) disable iff (rst) !load |=> $stable(cmp_act));  // R8
endmodule

// File: rtl/pwm3_dead_gate.sv
module pwm3_dead_gate #(
  parameter int CNT_W = 12,
  parameter int DEAD  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] duty,
  output logic             hi,
  output logic             lo
);
  localparam int              DT_W    = (DEAD > 1) ? $clog2(DEAD) : 1;
  localparam logic [DT_W-1:0] DT_LOAD = DT_W'(DEAD - 1);

  logic            want_hi;
  logic            want_q;
  logic [DT_W-1:0] gap;

  assign want_hi = (cnt < duty);

  always_ff @(posedge clk) begin
    if (rst) begin
      want_q <= 1'b0;
      gap    <= DT_LOAD;
      hi     <= 1'b0;
      lo     <= 1'b0;
    end else if (want_hi != want_q) begin
      want_q <= want_hi;
      gap    <= DT_LOAD;
      hi     <= 1'b0;
      lo     <= 1'b0;
    end else if (gap != '0) begin
      gap <= gap - 1'b1;
      hi  <= 1'b0;
      lo  <= 1'b0;
    end else begin
      hi <= want_q;
      lo <= !want_q;
    end
  end

  AST_NO_SHOOT:   assert property (@(posedge clk) disable iff (rst) !(hi && lo));         // R7
  AST_LO_AFTER:   assert property (@(posedge clk) disable iff (rst) $rose(lo) |-> !$past(hi)); // R7
  AST_HI_AFTER:   assert property (@(posedge clk) disable iff (rst) $rose(hi) |-> !$past(lo)); // R7
endmodule

// File: rtl/tri_pwm_adc_timer.sv
module tri_pwm_adc_timer #(
  parameter int              CNT_W      = 12,
  parameter int              PERIOD     = 2000,
  parameter int              DEAD       = 16,
  parameter bit              HALF_SHIFT = 1'b0,
  parameter pwm3_pkg::turn_e RELOAD_AT  = pwm3_pkg::TURN_TOP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] duty_u,
  input  logic [CNT_W-1:0] duty_v,
  input  logic [CNT_W-1:0] duty_w,
  input  logic [CNT_W-1:0] trig_cmp,
  output logic [2:0]       gate_hi,
  output logic [2:0]       gate_lo,
  output logic             adc_trig,
  output logic             dir_down
);
  localparam int               NPH = pwm3_pkg::PHASES;
  localparam logic [CNT_W-1:0] TOP = CNT_W'(PERIOD);

  logic [CNT_W-1:0]          cnt;
  logic                      falling;
  logic                      load;
  logic [NPH-1:0][CNT_W-1:0] duty_in;
  logic [NPH-1:0][CNT_W-1:0] duty_act;
  logic [CNT_W-1:0]          cmp_act;

  assign duty_in = {duty_w, duty_v, duty_u};

  pwm3_updown_ctr #(.CNT_W(CNT_W), .PERIOD(PERIOD), .START_HIGH(HALF_SHIFT)) u_ctr (
    .clk(clk), .rst(rst), .cnt(cnt), .falling(falling)
  );

  generate
    if (RELOAD_AT == pwm3_pkg::TURN_TOP) begin : g_load_top
      assign load = (cnt == TOP);
    end else begin : g_load_bot
      assign load = (cnt == '0);
    end
  endgenerate

  pwm3_shadow #(.CNT_W(CNT_W), .N(NPH)) u_shadow (
    .clk(clk), .rst(rst), .wr_en(wr_en), .duty_in(duty_in), .cmp_in(trig_cmp),
    .load(load), .duty_act(duty_act), .cmp_act(cmp_act)
  );

  generate
    for (genvar p = 0; p < NPH; p++) begin : g_phase
      pwm3_dead_gate #(.CNT_W(CNT_W), .DEAD(DEAD)) u_gate (
        .clk(clk), .rst(rst), .cnt(cnt), .duty(duty_act[p]),
        .hi(gate_hi[p]), .lo(gate_lo[p])
      );
    end
  endgenerate

  // Trigger and direction are registered so they line up with the gates.
  always_ff @(posedge clk) begin
    if (rst) begin
      adc_trig <= 1'b0;
      dir_down <= 1'b0;
    end else begin
      adc_trig <= falling && (cnt == cmp_act);
      dir_down <= falling;
    end
  end

  AST_TRIG_DIR:   assert property (@(posedge clk) disable iff (rst) adc_trig |-> dir_down);  // R2
  AST_TRIG_PULSE: assert property (@(posedge clk) disable iff (rst) adc_trig |=> !adc_trig); // R2
  AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (rst) (cmp_act == '0) |=> !adc_trig); // R4
endmodule

// File: tb/tri_pwm_adc_timer_test.sv
module tri_pwm_adc_timer_test;
  localparam int CW = 12;
  localparam int P  = 40;
  localparam int DT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [CW-1:0] duty_u = '0, duty_v = '0, duty_w = '0, trig_cmp = '0;
  logic [2:0] hi_a, lo_a, hi_b, lo_b;
  logic trig_a, trig_b, dir_a, dir_b;

  always #2 clk = ~clk;

  tri_pwm_adc_timer #(.CNT_W(CW), .PERIOD(P), .DEAD(DT), .HALF_SHIFT(1'b0)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .duty_u(duty_u), .duty_v(duty_v), .duty_w(duty_w),
    .trig_cmp(trig_cmp), .gate_hi(hi_a), .gate_lo(lo_a), .adc_trig(trig_a), .dir_down(dir_a)
  );

  tri_pwm_adc_timer #(.CNT_W(CW), .PERIOD(P), .DEAD(DT), .HALF_SHIFT(1'b1)) uut_b (
    .clk(clk), .rst(rst), .wr_en(wr_en), .duty_u(duty_u), .duty_v(duty_v), .duty_w(duty_w),
    .trig_cmp(trig_cmp), .gate_hi(hi_b), .gate_lo(lo_b), .adc_trig(trig_b), .dir_down(dir_b)
  );

  typedef struct {
    int    hi [3];
    int    lo [3];
    string tag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_hi(int d);
    int v;
    if (d == 0) return 0;
    if (d > P) return 2 * P;
    v = 2 * d - 1 - DT;
    return (v < 0) ? 0 : v;
  endfunction

  function automatic int exp_lo(int d);
    int v;
    if (d == 0) return 2 * P;
    if (d > P) return 0;
    v = 2 * P - 2 * d + 1 - DT;
    return (v < 0) ? 0 : v;
  endfunction

  // Monitor: one window per PWM period, closed by each trigger of uut.
  int  m_hi [3];
  int  m_lo [3];
  int  m_dir, m_trig, m_cyc;
  bit  win_open = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (win_open) begin
        for (int p = 0; p < 3; p++) begin
          m_hi[p] += int'(hi_a[p]);
          m_lo[p] += int'(lo_a[p]);
        end
        m_dir  += int'(dir_a);
        m_trig += int'(trig_a);
        m_cyc  += 1;
      end
      if (trig_a) begin
        if (win_open && q.size() > 0) begin
          exp_t e;
          e = q.pop_front();
          for (int p = 0; p < 3; p++) begin
            chk($sformatf("R5/R6/R8 %s high-side on-time phase %0d", e.tag, p), m_hi[p], e.hi[p]);
            chk($sformatf("R5/R6/R8 %s low-side on-time phase %0d", e.tag, p), m_lo[p], e.lo[p]);
          end
          chk($sformatf("R1 %s falling cycles per period", e.tag), m_dir, P);
          chk($sformatf("R1 %s period length", e.tag), m_cyc, 2 * P);
          chk($sformatf("R2 %s triggers per period", e.tag), m_trig, 1);
          chk($sformatf("R2 %s dir_down during trigger", e.tag), int'(dir_a), 1);
        end
        for (int p = 0; p < 3; p++) begin
          m_hi[p] = 0;
          m_lo[p] = 0;
        end
        m_dir = 0; m_trig = 0; m_cyc = 0;
        win_open = 1'b1;
      end
    end
  end

  task automatic write_regs(int a, int b, int c, int cmp);
    @(negedge clk);
    duty_u = CW'(a); duty_v = CW'(b); duty_w = CW'(c); trig_cmp = CW'(cmp);
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_trig();
    do @(negedge clk); while (!trig_a);
  endtask

  task automatic push_exp(int a, int b, int c, string tag);
    exp_t e;
    e.hi[0] = exp_hi(a); e.hi[1] = exp_hi(b); e.hi[2] = exp_hi(c);
    e.lo[0] = exp_lo(a); e.lo[1] = exp_lo(b); e.lo[2] = exp_lo(c);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wait_drained();
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic run_case(int a, int b, int c, int cmp, string tag);
    write_regs(a, b, c, cmp);
    repeat (3) wait_trig();
    @(negedge clk);
    push_exp(a, b, c, tag);
    wait_drained();
  endtask

  task automatic trig_offset(int cmp);
    int t0;
    while (dir_a) @(negedge clk);
    while (!dir_a) @(negedge clk);
    t0 = cyc;
    while (!trig_a) @(negedge clk);
    chk($sformatf("R3 trigger delay after falling start, C=%0d", cmp), cyc - t0, P - cmp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 gate_hi in reset", int'(hi_a), 0);
    chk("R10 gate_lo in reset", int'(lo_a), 0);
    chk("R10 adc_trig in reset", int'(trig_a), 0);
    chk("R10 dir_down in reset", int'(dir_a), 0);
    @(negedge clk);
    rst = 1'b0;

    // Mixed duties: normal, above the top, zero.
    run_case(10, 41, 0, 30, "mixed");
    trig_offset(30);

    // Compare at the top: trigger coincides with the reload point.
    run_case(3, 38, 20, P, "cmp-at-top");
    trig_offset(P);

    // R8: a write just after a trigger must not touch the current period.
    run_case(10, 10, 10, 30, "steady10");
    wait_trig();
    write_regs(5, 5, 5, 30);
    push_exp(10, 10, 10, "R8 mid-period write");
    wait_drained();
    @(negedge clk);
    push_exp(5, 5, 5, "after reload");
    wait_drained();

    // R9: shifted instance trails by half a period.
    begin
      int t0;
      while (!trig_a) @(negedge clk);
      t0 = cyc;
      @(negedge clk);
      while (!trig_b) @(negedge clk);
      chk("R9 half-period trigger offset", cyc - t0, P);
    end

    // R4: compare 0 is never reached while falling.
    begin
      int n;
      n = 0;
      write_regs(12, 12, 12, 0);
      repeat (3 * P) @(negedge clk);
      repeat (6 * P) begin
        @(negedge clk);
        n += int'(trig_a);
      end
      chk("R4 triggers with compare 0", n, 0);
    end

    run_case(P, 1, 25, 15, "edges");
    trig_offset(15);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule